// File: doc/BRIEF.md
# Mixed-Sign Fractional/Integer Multiplier

This block multiplies two 16-bit operands. Each operand has its own flag that marks it as signed or unsigned. Each operand is widened by one bit to match its flag, so every sign combination runs through a single signed product core. The raw product then passes to a scaling step:

- A DSP-class operation in fractional mode doubles the product, which gives a 1.31 result whose low bit is always zero.
- Every other operation keeps the plain integer product.

The integer/fractional choice is a writable mode bit. It comes out of reset set to fractional, and it has no effect on MCU-class operations.

One register stage sits between the operands and the results. An input strobe captures the operands. One clock later a valid flag marks two outputs:

- A 32-bit result word.
- A 40-bit copy of the same result, sign-extended from bit 32, ready to feed an accumulator.

The 40-bit copy keeps the fractional +1.0 that arises from the most negative value squared. The 32-bit word wraps with no saturation.

Top module: `mulx_unit`

## Requirements
- R1: An operand whose flag is 1 is sign-extended from 16 to 17 bits; an operand whose flag is 0 is zero-extended, so an unsigned 0xFFFF counts as 65535 and a signed 0xFFFF counts as -1.
- R2: Signed×signed, signed×unsigned, unsigned×signed and unsigned×unsigned operands all give the exact two's-complement product of the widened values.
- R3: When `dsp_op` is 1 and the mode bit is 1 (fractional), the result is the product shifted left by one, and bit 0 of `prod32` is 0.
- R4: When `dsp_op` is 1 and the mode bit is 0 (integer), the result is the unshifted product.
- R5: When `dsp_op` is 0 (MCU class), the result is the unshifted product whatever the mode bit holds.
- R6: While reset is active and after it ends, `out_valid` is 0. After reset the mode bit is 1 (fractional) until it is written.
- R7: When `mode_we` is 1 at a rising edge, the mode bit takes `mode_frac_in`. An operation captured on that same edge still uses the old mode. When `mode_we` is 0, the mode bit holds its value.
- R8: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` at 1.
- R9: `prod32` holds the low 32 bits of the scaled product, with no saturation (fractional 0x8000×0x8000 signed gives 0x80000000).
- R10: `prod40` bits 31:0 equal `prod32`, and bits 39:32 all copy bit 32 of the scaled product (fractional 0x8000×0x8000 signed gives 0x0080000000).
- R11: While `in_valid` is 0, `prod32` and `prod40` keep the result of the last captured operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Capture strobe for operands, flags and class |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| opa_signed | input | 1 | 1: opa is two's complement, 0: opa is unsigned |
| opb_signed | input | 1 | 1: opb is two's complement, 0: opb is unsigned |
| dsp_op | input | 1 | 1: DSP-class operation (obeys mode), 0: MCU-class (always integer) |
| mode_we | input | 1 | Write enable for the mode bit |
| mode_frac_in | input | 1 | New mode value: 1 fractional, 0 integer |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| prod32 | output | 32 | Scaled product, low 32 bits |
| prod40 | output | 40 | Scaled product sign-extended from bit 32 |

## Verification
The main sweep pairs the operand values 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF under all four sign-flag settings. It repeats the sweep in three settings: DSP-class fractional, DSP-class integer, and MCU-class with the mode left at fractional. Because 0x8000 and 0xFFFF change value with their flags, this sweep shows whether each operand was zero- or sign-extended. Comparing the three settings shows whether the doubling applies only to DSP-class fractional work. The directed vectors add several cases:
- The +1.0 case, which separates sign extension from bit 32 from sign extension from bit 31.
- A mode write in the same cycle as an operation, which shows which mode value that operation uses.
- Idle cycles, which show that the outputs hold and that the valid flag drops.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

  // Meaning of the stored mode bit.
  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } mulx_mode_e;

  // Operation class carried with each request.
  typedef enum logic {
    CLS_MCU = 1'b0,
    CLS_DSP = 1'b1
  } mulx_cls_e;

  localparam int unsigned MULX_OPERANDS = 2;

endpackage

// File: rtl/mulx_widen.sv
// Widens one operand by a single bit according to its signedness flag.
module mulx_widen #(
  parameter int unsigned OP_W = 16,
  localparam int unsigned EXT_W = OP_W + 1
) (
  input  logic [OP_W-1:0]  raw,
  input  logic             is_signed,
  output logic [EXT_W-1:0] wide
);

  logic top_fill;

  always_comb begin
    top_fill = is_signed & raw[OP_W-1];
    wide     = {top_fill, raw};
  end

endmodule

// File: rtl/mulx_core.sv
// Signed product of two widened operands, kept to KEEP_W low bits.
module mulx_core #(
  parameter int unsigned EXT_W  = 17,
  parameter int unsigned KEEP_W = 33
) (
  input  logic [EXT_W-1:0]  a,
  input  logic [EXT_W-1:0]  b,
  output logic [KEEP_W-1:0] p
);

  localparam int unsigned PAD_W = KEEP_W - EXT_W;

  logic signed [KEEP_W-1:0] a_ext;
  logic signed [KEEP_W-1:0] b_ext;

  always_comb begin
    a_ext = {{PAD_W{a[EXT_W-1]}}, a};
    b_ext = {{PAD_W{b[EXT_W-1]}}, b};
    p     = a_ext * b_ext;
  end

endmodule

// File: rtl/mulx_scale.sv
// Optional one-bit left shift with the vacated low bit cleared.
module mulx_scale #(
  parameter int unsigned KEEP_W = 33
) (
  input  logic [KEEP_W-1:0] p_in,
  input  logic              shift_en,
  output logic [KEEP_W-1:0] p_out
);

  always_comb begin
    if (shift_en) begin
      p_out = {p_in[KEEP_W-2:0], 1'b0};
    end else begin
      p_out = p_in;
    end
  end

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
  import mulx_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned OUT_W = 32,
  parameter int unsigned ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  opa,
  input  logic [OP_W-1:0]  opb,
  input  logic             opa_signed,
  input  logic             opb_signed,
  input  logic             dsp_op,
  input  logic             mode_we,
  input  logic             mode_frac_in,
  output logic             out_valid,
  output logic [OUT_W-1:0] prod32,
  output logic [ACC_W-1:0] prod40
);

  localparam int unsigned EXT_W  = OP_W + 1;
  localparam int unsigned KEEP_W = OUT_W + 1;
  localparam int unsigned SEXT_W = ACC_W - KEEP_W;

  // ---------------- reset release synchroniser ----------------
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe[1];

  // ---------------- mode bit ----------------
  mulx_mode_e mode_q;
  mulx_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) begin
      mode_d = mulx_mode_e'(mode_frac_in);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= MODE_FRAC;
    end else begin
      mode_q <= mode_d;
    end
  end

  // ---------------- operand widening ----------------
  logic [OP_W-1:0]  raw_op  [MULX_OPERANDS];
  logic             raw_sgn [MULX_OPERANDS];
  logic [EXT_W-1:0] wide_op [MULX_OPERANDS];

  always_comb begin
    raw_op[0]  = opa;
    raw_op[1]  = opb;
    raw_sgn[0] = opa_signed;
    raw_sgn[1] = opb_signed;
  end

  for (genvar g = 0; g < MULX_OPERANDS; g++) begin : g_widen
    mulx_widen #(.OP_W(OP_W)) u_widen (
      .raw       (raw_op[g]),
      .is_signed (raw_sgn[g]),
      .wide      (wide_op[g])
    );
  end

  // ---------------- product and scaling ----------------
  logic [KEEP_W-1:0] prod_raw;
  logic [KEEP_W-1:0] prod_scaled;
  logic              scale_en;

  mulx_core #(.EXT_W(EXT_W), .KEEP_W(KEEP_W)) u_core (
    .a (wide_op[0]),
    .b (wide_op[1]),
    .p (prod_raw)
  );

  always_comb begin
    scale_en = (mulx_cls_e'(dsp_op) == CLS_DSP) && (mode_q == MODE_FRAC);
  end

  mulx_scale #(.KEEP_W(KEEP_W)) u_scale (
    .p_in     (prod_raw),
    .shift_en (scale_en),
    .p_out    (prod_scaled)
  );

  // ---------------- result register ----------------
  logic              vld_q;
  logic              vld_d;
  logic [KEEP_W-1:0] res_q;
  logic [KEEP_W-1:0] res_d;
  logic              res_en;

  always_comb begin
    vld_d  = in_valid;
    res_en = in_valid;
    res_d  = prod_scaled;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (res_en) begin
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign prod32    = res_q[OUT_W-1:0];
  assign prod40    = {{SEXT_W{res_q[OUT_W]}}, res_q};

  // ---------------- assertions ----------------
  // R8: valid output follows the strobe by exactly one clock
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid == $past(in_valid));

  // R3: fractional DSP results always have a clear low bit
  a_r3_lsb_clear: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && dsp_op && mode_q == MODE_FRAC) |=> (prod32[0] == 1'b0));

  // R10: wide output agrees with narrow output and is a clean sign extension
  a_r10_sext: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> ((prod40[OUT_W-1:0] == prod32) &&
                   ((prod40[ACC_W-1:OUT_W] == '0) || (prod40[ACC_W-1:OUT_W] == '1))));

  // R1: unsigned by unsigned, unscaled, can never be negative
  a_r1_uu_nonneg: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !opa_signed && !opb_signed && !(dsp_op && mode_q == MODE_FRAC))
      |=> (prod40[ACC_W-1:OUT_W] == '0));

  // R7: the mode bit only moves on a write
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mode_we |=> $stable(mode_q));

  // R11: results hold while idle
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !in_valid) |=> ($stable(prod32) && $stable(prod40)));

  // R6: reset leaves the mode at fractional
  a_r6_mode_reset: assert property (@(posedge clk)
    $rose(rst_q_n) |-> (mode_q == MODE_FRAC));

endmodule

// File: tb/sim_mulx_unit.sv
module sim_mulx_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] opa;
  logic [15:0] opb;
  logic        opa_signed;
  logic        opb_signed;
  logic        dsp_op;
  logic        mode_we;
  logic        mode_frac_in;
  logic        out_valid;
  logic [31:0] prod32;
  logic [39:0] prod40;

  int total_cnt = 0;
  int bad_cnt   = 0;
  int cycles    = 0;
  bit finished  = 0;

  mulx_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opa(opa), .opb(opb), .opa_signed(opa_signed), .opb_signed(opb_signed),
    .dsp_op(dsp_op), .mode_we(mode_we), .mode_frac_in(mode_frac_in),
    .out_valid(out_valid), .prod32(prod32), .prod40(prod40)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [15:0] VALS [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        sa;
    logic        sb;
    logic        dsp;
    logic        frac;
    logic [31:0] e32;
    logic [39:0] e40;
  } dvec_t;

  localparam dvec_t DIRV [6] = '{
    '{16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h8000_0000, 40'h00_8000_0000},
    '{16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFE_0001, 40'h00_FFFE_0001},
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0002, 40'h00_0000_0002},
    '{16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 40'hFF_FFFF_FFFF},
    '{16'h8000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_8000, 40'hFF_8000_8000},
    '{16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b1, 32'h7FFE_0002, 40'h00_7FFE_0002}
  };

  // Behavioural reference built from the requirements
  function automatic logic [39:0] ref40(input logic [15:0] a, input logic [15:0] b,
                                        input logic sa, input logic sb, input logic scale);
    longint ea;
    longint eb;
    longint p;
    logic [63:0] pb;
    ea = sa ? longint'($signed(a)) : longint'({48'd0, a});
    eb = sb ? longint'($signed(b)) : longint'({48'd0, b});
    p  = ea * eb;
    if (scale) p = p * 2;
    pb = 64'(p);
    return {{7{pb[32]}}, pb[32:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic f);
    @(negedge clk);
    mode_we      = 1'b1;
    mode_frac_in = f;
    @(negedge clk);
    mode_we      = 1'b0;
  endtask

  // Issue one operation and compare at the following negedge
  task automatic run_op(input string req, input logic [15:0] a, input logic [15:0] b,
                        input logic sa, input logic sb, input logic dsp,
                        input logic [31:0] e32, input logic [39:0] e40);
    @(negedge clk);
    in_valid = 1'b1; opa = a; opb = b; opa_signed = sa; opb_signed = sb; dsp_op = dsp;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " p32"}, 64'(prod32), 64'(e32));
    chk({req, " p40"}, 64'(prod40), 64'(e40));
  endtask

  initial begin
    logic [39:0] e;
    rst_n = 1'b0; in_valid = 1'b0; opa = '0; opb = '0;
    opa_signed = 1'b0; opb_signed = 1'b0; dsp_op = 1'b0;
    mode_we = 1'b0; mode_frac_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 valid after reset", 64'(out_valid), 64'd0);

    // R6: mode is fractional without any write: 0x4000^2 doubled
    run_op("R6 frac default", 16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, 32'h2000_0000, 40'h00_2000_0000);

    // Sweep: md 0 DSP frac (R3), md 1 DSP int (R4), md 2 MCU with frac set (R5)
    for (int md = 0; md < 3; md++) begin
      set_mode(md != 1);
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          for (int sg = 0; sg < 4; sg++) begin
            e = ref40(VALS[i], VALS[j], sg[1], sg[0], md == 0);
            run_op(md == 0 ? "R1 R2 R3 R9 R10" : (md == 1 ? "R1 R2 R4" : "R2 R5"),
                   VALS[i], VALS[j], sg[1], sg[0], md != 2, e[31:0], e);
          end
        end
      end
    end

    // Directed vectors with fixed expected values (R9, R10, R2)
    for (int k = 0; k < 6; k++) begin
      set_mode(DIRV[k].frac);
      run_op("R9 R10 directed", DIRV[k].a, DIRV[k].b, DIRV[k].sa, DIRV[k].sb,
             DIRV[k].dsp, DIRV[k].e32, DIRV[k].e40);
    end

    // R7: a write in the same cycle as an operation does not affect it
    set_mode(1'b0);
    @(negedge clk);
    in_valid = 1'b1; opa = 16'h0003; opb = 16'h0005; opa_signed = 1'b0; opb_signed = 1'b0;
    dsp_op = 1'b1; mode_we = 1'b1; mode_frac_in = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; mode_we = 1'b0;
    chk("R7 same-cycle old mode", 64'(prod32), 64'd15);
    run_op("R7 new mode", 16'h0003, 16'h0005, 1'b0, 1'b0, 1'b1, 32'd30, 40'd30);

    // R8, R11: idle cycles drop valid and hold data
    @(negedge clk);
    chk("R8 valid drops", 64'(out_valid), 64'd0);
    chk("R11 p32 held", 64'(prod32), 64'd30);
    @(negedge clk);
    opa = 16'h1234; opb = 16'h5678; dsp_op = 1'b0;
    @(negedge clk);
    chk("R11 p40 held", 64'(prod40), 64'd30);
    chk("R8 valid idle", 64'(out_valid), 64'd0);

    // R6: reset in the middle clears valid and restores fractional mode
    set_mode(1'b0);
    @(negedge clk);
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 valid cleared", 64'(out_valid), 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_op("R6 frac after reset", 16'h0003, 16'h0005, 1'b0, 1'b0, 1'b1, 32'd30, 40'd30);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total_cnt++;
        bad_cnt++;
        $display("FAIL watchdog act=%0d exp<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
        $finish;
      end
    end
  end

endmodule